// File: doc/BRIEF.md
# Program/Erase Busy Status Responder

This block sits on the read path of a nonvolatile byte array. It serves reads while a byte-program or whole-array erase operation is in progress. An accepted start request records the operation kind, the target address and the byte being written. It then holds a busy flag for an internally counted number of clock cycles. The host supplies no timing of its own for this interval.

While busy is set, every read strobe returns a status byte instead of plain array contents. Software can then detect completion in either of two ways. It can compare bit 7 against the byte it wrote, or it can watch bit 6 change between consecutive reads. Once the interval runs out, reads again return the array data supplied from outside, unchanged.

Command decoding and the array storage are outside the block. The array data for the current read address arrives on an input. The read result is registered and appears on the cycle after the strobe.

Top module: `busy_status_top`

## Requirements
- R1: While reset is high and on the first cycle after it, `busy_o` is 0 and `rd_data_o` is 8'h00.
- R2: A start accepted at a clock edge raises `busy_o` after that edge. `busy_o` then stays high for exactly PROG_CYCLES clock cycles for a program (`op_erase_i`=0) or ERASE_CYCLES cycles for an erase (`op_erase_i`=1), and then falls.
- R3: A start request seen while `busy_o` is high is ignored: the busy length, the operation kind, the address and the data of the running operation are all unchanged.
- R4: During a program, a read at the recorded address returns bit 7 as the complement of bit 7 of the recorded data byte.
- R5: During an erase, every read returns bit 7 as 0, whatever the address.
- R6: During an operation, bit 6 of a read result is 0 on the first read after the start and inverts on each later read. Clock cycles without a read strobe do not advance it.
- R7: During an operation, bits 5..0 always pass the array data. During a program, bit 7 of a read at any other address also passes the array data.
- R8: When `busy_o` is low, a read returns the array data byte unchanged, so bit 6 no longer changes from read to read.
- R9: `rd_data_o` is updated only on the clock edge that samples `rd_i` high. It holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin an operation |
| op_erase_i | input | 1 | Operation kind with the start: 0 program, 1 erase |
| addr_i | input | AW | Byte address loaded with the start |
| wdata_i | input | 8 | Data byte loaded with the start |
| rd_i | input | 1 | Read strobe, one cycle per read access |
| rd_addr_i | input | AW | Address of the read access |
| arr_data_i | input | 8 | Stored array byte at `rd_addr_i`, from outside storage |
| rd_data_o | output | 8 | Registered read result |
| busy_o | output | 1 | High while an operation is in progress |

## Verification
The assertions assume that `arr_data_i` reflects `rd_addr_i` in the same cycle. They also assume that `op_erase_i`, `addr_i` and `wdata_i` are meaningful only in cycles when `start_i` is high, and that reset is held from time zero. The bench keeps within these limits. It derives the array byte combinationally from the read address, and it changes all inputs only at the falling clock edge. Each run issues one start to an idle block. It then offers a deliberate conflicting start of the opposite kind, with a different address and inverted data, two cycles later. The pattern of reads, idle cycles and addresses follows a fixed arithmetic schedule, so the toggle, the poll bit and the busy window are all predicted in the bench.

// File: rtl/busy_stat_pkg.sv
package busy_stat_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned POLL_BIT = 7;
    localparam int unsigned TGL_BIT  = 6;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_kind_e;

    typedef struct packed {
        op_kind_e            kind;
        logic [BYTE_W-1:0]   data;
    } op_info_t;

    // Status byte returned while an operation is running.
    function automatic logic [BYTE_W-1:0] status_byte(
        input op_kind_e          kind,
        input logic              addr_hit,
        input logic [BYTE_W-1:0] loaded,
        input logic              tgl,
        input logic [BYTE_W-1:0] arr
    );
        logic [BYTE_W-1:0] s;
        s = arr;
        s[TGL_BIT] = tgl;
        if (kind == OP_ERASE) begin
            s[POLL_BIT] = 1'b0;
        end else if (addr_hit) begin
            s[POLL_BIT] = ~loaded[POLL_BIT];
        end
        return s;
    endfunction

endpackage

// File: rtl/busy_timer.sv
module busy_timer
    import busy_stat_pkg::*;
#(
    parameter int unsigned PROG_CYCLES  = 5,
    parameter int unsigned ERASE_CYCLES = 9
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_i,
    input  op_kind_e kind_i,
    output logic     busy_o
);
    localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] PROG_LEN  = CW'(PROG_CYCLES);
    localparam logic [CW-1:0] ERASE_LEN = CW'(ERASE_CYCLES);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (accept_i) begin
            remain_q <= (kind_i == OP_ERASE) ? ERASE_LEN : PROG_LEN;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy_o = (remain_q != '0);
endmodule

// File: rtl/busy_toggle.sv
module busy_toggle (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    input  logic adv_i,
    output logic tgl_o
);
    logic tgl_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            tgl_q <= 1'b0;
        end else if (adv_i) begin
            tgl_q <= ~tgl_q;
        end
    end

    assign tgl_o = tgl_q;
endmodule

// File: rtl/busy_ctx_reg.sv
module busy_ctx_reg
    import busy_stat_pkg::*;
#(
    parameter int unsigned AW = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  op_kind_e          kind_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [BYTE_W-1:0] data_i,
    output op_info_t          info_o,
    output logic [AW-1:0]     addr_o
);
    op_info_t      info_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            info_q <= '{kind: OP_PROG, data: '0};
            addr_q <= '0;
        end else if (load_i) begin
            info_q <= '{kind: kind_i, data: data_i};
            addr_q <= addr_i;
        end
    end

    assign info_o = info_q;
    assign addr_o = addr_q;
endmodule

// File: rtl/busy_status_mux.sv
module busy_status_mux
    import busy_stat_pkg::*;
#(
    parameter int unsigned AW = 19
) (
    input  logic              busy_i,
    input  op_info_t          info_i,
    input  logic [AW-1:0]     lat_addr_i,
    input  logic [AW-1:0]     rd_addr_i,
    input  logic              tgl_i,
    input  logic [BYTE_W-1:0] arr_i,
    output logic [BYTE_W-1:0] byte_o
);
    logic hit;

    always_comb begin
        hit = (rd_addr_i == lat_addr_i);
        if (busy_i) begin
            byte_o = status_byte(info_i.kind, hit, info_i.data, tgl_i, arr_i);
        end else begin
            byte_o = arr_i;
        end
    end
endmodule

// File: rtl/busy_status_top.sv
module busy_status_top
    import busy_stat_pkg::*;
#(
    parameter int unsigned AW           = 19,
    parameter int unsigned PROG_CYCLES  = 5,
    parameter int unsigned ERASE_CYCLES = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          op_erase_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    input  logic          rd_i,
    input  logic [AW-1:0] rd_addr_i,
    input  logic [7:0]    arr_data_i,
    output logic [7:0]    rd_data_o,
    output logic          busy_o
);
    logic              busy;
    logic              accept;
    logic              tgl;
    op_kind_e          kind_in;
    op_info_t          info;
    logic [AW-1:0]     lat_addr;
    logic [BYTE_W-1:0] next_byte;
    logic [BYTE_W-1:0] rd_data_q;

    assign kind_in = op_kind_e'(op_erase_i);
    assign accept  = start_i && !busy;

    busy_timer #(
        .PROG_CYCLES  (PROG_CYCLES),
        .ERASE_CYCLES (ERASE_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .kind_i   (kind_in),
        .busy_o   (busy)
    );

    busy_ctx_reg #(.AW(AW)) u_ctx (
        .clk    (clk),
        .rst    (rst),
        .load_i (accept),
        .kind_i (kind_in),
        .addr_i (addr_i),
        .data_i (wdata_i),
        .info_o (info),
        .addr_o (lat_addr)
    );

    busy_toggle u_tgl (
        .clk     (clk),
        .rst     (rst),
        .clear_i (accept),
        .adv_i   (rd_i && busy),
        .tgl_o   (tgl)
    );

    busy_status_mux #(.AW(AW)) u_mux (
        .busy_i     (busy),
        .info_i     (info),
        .lat_addr_i (lat_addr),
        .rd_addr_i  (rd_addr_i),
        .tgl_i      (tgl),
        .arr_i      (arr_data_i),
        .byte_o     (next_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else if (rd_i) begin
            rd_data_q <= next_byte;
        end
    end

    assign rd_data_o = rd_data_q;
    assign busy_o    = busy;
endmodule

// File: rtl/busy_status_chk.sv
module busy_status_chk
    import busy_stat_pkg::*;
#(
    parameter int unsigned AW = 19
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic          rd_i,
    input logic [AW-1:0] rd_addr_i,
    input logic [7:0]    arr_data_i,
    input logic [7:0]    rd_data_o,
    input logic          busy_o,
    input logic          tgl,
    input op_info_t      info,
    input logic [AW-1:0] lat_addr
);
    p_busy_src_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> ($stable(lat_addr) && $stable(info)));

    p_prog_poll_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_i && busy_o && info.kind == OP_PROG && rd_addr_i == lat_addr)
        |=> (rd_data_o[7] != $past(info.data[7])));

    p_erase_poll_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_i && busy_o && info.kind == OP_ERASE) |=> !rd_data_o[7]);

    p_tgl_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (!rd_i && !start_i) |=> $stable(tgl));

    p_idle_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !busy_o) |=> (rd_data_o == $past(arr_data_i)));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(rd_data_o));
endmodule

bind busy_status_top busy_status_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .rd_addr_i  (rd_addr_i),
    .arr_data_i (arr_data_i),
    .rd_data_o  (rd_data_o),
    .busy_o     (busy_o),
    .tgl        (tgl),
    .info       (info),
    .lat_addr   (lat_addr)
);

// File: tb/busy_status_top_bench.sv
module busy_status_top_bench;
    localparam int AW = 19;
    localparam int PC = 5;
    localparam int EC = 9;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic          op_erase_i;
    logic [AW-1:0] addr_i;
    logic [7:0]    wdata_i;
    logic          rd_i;
    logic [AW-1:0] rd_addr_i;
    logic [7:0]    arr_data_i;
    logic [7:0]    rd_data_o;
    logic          busy_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] arr_of(logic [AW-1:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd37;
        return m ^ 8'hC3;
    endfunction

    assign arr_data_i = arr_of(rd_addr_i);

    busy_status_top #(.AW(AW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_busy_status_top (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .op_erase_i (op_erase_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rd_i       (rd_i),
        .rd_addr_i  (rd_addr_i),
        .arr_data_i (arr_data_i),
        .rd_data_o  (rd_data_o),
        .busy_o     (busy_o)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic run(bit erase, logic [AW-1:0] a, logic [7:0] d);
        int         n;
        logic       tgl;
        logic [7:0] exp;
        logic [7:0] prev;
        logic [AW-1:0] ra;
        bit         rd;
        string      tag;
        n   = erase ? EC : PC;
        tgl = 1'b0;
        @(negedge clk);
        start_i = 1'b1; op_erase_i = erase; addr_i = a; wdata_i = d;
        @(negedge clk);
        start_i = 1'b0;
        prev = rd_data_o;
        for (int e = 1; e <= n + 2; e++) begin
            // R2 R3: busy window keeps its length despite the conflicting start
            check8("R2 R3 busy window", {7'b0, busy_o}, {7'b0, (e <= n)});
            rd = (e % 3) != 0;
            ra = (e % 2 == 1) ? a : a + 1;
            rd_i = rd;
            rd_addr_i = ra;
            if (e == 2) begin
                start_i = 1'b1; op_erase_i = !erase; addr_i = a + 5; wdata_i = ~d;
            end
            exp = arr_of(ra);
            if (e > n) tag = "R8 idle read";
            else if (erase) tag = "R5 R6 R7 erase status";
            else if (ra == a) tag = "R4 R6 R7 program poll";
            else tag = "R7 R6 program other address";
            if (rd && e <= n) begin
                if (erase) exp[7] = 1'b0;
                else if (ra == a) exp[7] = ~d[7];
                exp[6] = tgl;
                tgl = ~tgl;
            end
            @(negedge clk);
            rd_i = 1'b0;
            start_i = 1'b0;
            if (rd) check8(tag, rd_data_o, exp);
            else check8("R9 hold without strobe", rd_data_o, prev);
            prev = rd_data_o;
        end
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; op_erase_i = 1'b0; addr_i = '0;
        wdata_i = '0; rd_i = 1'b0; rd_addr_i = '0;
        repeat (3) @(negedge clk);
        check8("R1 reset busy", {7'b0, busy_o}, 8'h00);
        check8("R1 reset data", rd_data_o, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check8("R1 post-reset busy", {7'b0, busy_o}, 8'h00);
        check8("R1 post-reset data", rd_data_o, 8'h00);
        for (int d = 0; d < 256; d += 17) run(1'b0, AW'(d * 101), 8'(d));
        for (int d = 3; d < 256; d += 51) run(1'b1, AW'(d * 7 + 1), 8'(d));
        run(1'b0, '1, 8'h80);
        run(1'b0, '0, 8'h7F);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule